// File: doc/BRIEF.md
# Two-Wire Slave Register Interface

This block lets a two-wire bus master read and write a byte-addressed register space inside the chip. It watches the clock and data lines and detects the bus conditions that start and stop a transfer. It accepts only its own 7-bit device address, loads an 8-bit location pointer, and then moves bytes one at a time or in a run, acknowledging each byte on the bus. The data pin is open-drain, so the block only asserts a pull-low enable and never drives the line high.

Locations 00h to 2Fh go to an external register file through a plain strobe port with one cycle of read latency. Three locations form a window onto a separate 2048-byte log memory. The first two hold the low and high parts of an 11-bit log index. The third reads or writes the log byte at that index and then advances the index. All other locations read as zero, and writes to them are dropped.

Both memory ports are plain strobe ports with no back-pressure. Each strobe lasts one clock, and read data must be presented on the cycle after a read strobe. The bus pace is slow compared with the clock, so neither port can stall a transfer.

Top module: `twowire_reg_slave`

## Requirements
- R1: A START (data falls while clock is high) begins a transfer from any state, including a repeated START in the middle of a transfer. A STOP (data rises while clock is high) ends the transfer and releases the data line.
- R2: The first byte after START is the 7-bit device address, default 52h, followed by the direction bit (1 = read). On a match the block pulls data low during the ninth clock. On a mismatch it gives no acknowledge, and it ignores the bus, including later writes, until the next START.
- R3: In a write, the first byte after the device address loads the location pointer. Each later byte is written to the pointed location. Every received byte is acknowledged.
- R4: In a read, bytes come from the pointed location, most significant bit first, with data changing only while the clock is low. A master acknowledge fetches the next byte. A master non-acknowledge ends the read with the data line released.
- R5: Locations 00h to 2Fh reach the register port, with the port address equal to pointer bits [5:0].
- R6: Locations 30h to 40h and 44h to FFh read 00h, and writes to them change neither memory port.
- R7: Location 41h holds log index bits [7:0]. Location 42h holds bits [10:8] in its data bits [2:0] and reads back with bits [7:3] zero. A written value above 07FFh therefore keeps only its low 11 bits.
- R8: A read or write at location 43h accesses the log memory at the log index, and the index then increments, wrapping from 7FFh to 000h.
- R9: The location pointer increments after every data byte, whether read or written, and wraps from FFh to 00h.
- R10: At most one of the four memory strobes is active in any cycle, and each write strobe lasts one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_drive_low | output | 1 | Pull-low enable for the open-drain data pin |
| reg_we | output | 1 | Register file write strobe |
| reg_re | output | 1 | Register file read strobe |
| reg_addr | output | 6 | Register file address |
| reg_wdata | output | 8 | Register file write data |
| reg_rdata | input | 8 | Register file read data, valid the cycle after reg_re |
| log_we | output | 1 | Log memory write strobe |
| log_re | output | 1 | Log memory read strobe |
| log_addr | output | 11 | Log memory address (the log index) |
| log_wdata | output | 8 | Log memory write data |
| log_rdata | input | 8 | Log memory read data, valid the cycle after log_re |

## Verification
The bench bit-bangs a master against a model register file and a model log memory, and it uses several transfer patterns:
- Sequential writes followed by a pointer-set-then-repeated-START read show that the pointer load, the auto-increment and the byte order are right.
- A transfer to a foreign device address, followed by a read-back of the location it aimed at, shows that an unmatched transfer is truly ignored rather than only left unacknowledged.
- Accesses to the log window separate index masking, read-back of the index bytes, and index wrap on both read and write.
- Reads from reserved locations and from FFh distinguish the zero fill from wrap of the location pointer.

// File: rtl/tw_pkg.sv
`timescale 1ns/1ps
package tw_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEVA,
    ST_DACK,
    ST_RXB,
    ST_RACK,
    ST_FETCH,
    ST_LOAD,
    ST_TXB,
    ST_TACK,
    ST_SKIP
  } tw_state_e;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_REG,
    RG_LPLO,
    RG_LPHI,
    RG_LOG
  } tw_region_e;

endpackage

// File: rtl/tw_line_sync.sv
`timescale 1ns/1ps
module tw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic start_p,
  output logic stop_p
);
  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic scl_d, sda_d;

  // resynchronisation chain, one stage per generate step
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff[0] <= 1'b1;
          sda_ff[0] <= 1'b1;
        end else begin
          scl_ff[0] <= scl_i;
          sda_ff[0] <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff[g] <= 1'b1;
          sda_ff[g] <= 1'b1;
        end else begin
          scl_ff[g] <= scl_ff[g-1];
          sda_ff[g] <= sda_ff[g-1];
        end
      end
    end
  end

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign start_p = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_p  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/tw_byte_engine.sv
`timescale 1ns/1ps
module tw_byte_engine
  import tw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h52,
  parameter int         PTR_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             start_p,
  input  logic             stop_p,
  input  logic [7:0]       rdata,
  output logic             drive_low,
  output logic             acc_wr,
  output logic             acc_rd,
  output logic [PTR_W-1:0] acc_ptr,
  output logic [7:0]       acc_wdata
);
  tw_state_e        state;
  logic [3:0]       bitcnt;
  logic [7:0]       shreg;
  logic [7:0]       wdata_q;
  logic [PTR_W-1:0] ptr;
  logic             first_q, rw_q, nack_q, wr_q, drive_q, scl_q;
  logic             scl_rise, scl_fall;

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      wdata_q <= '0;
      ptr     <= '0;
      first_q <= 1'b0;
      rw_q    <= 1'b0;
      nack_q  <= 1'b0;
      wr_q    <= 1'b0;
      drive_q <= 1'b0;
      scl_q   <= 1'b1;
    end else begin
      scl_q <= scl_s;
      wr_q  <= 1'b0;
      if (wr_q) ptr <= ptr + 1'b1;
      if (start_p) begin
        state   <= ST_DEVA;
        bitcnt  <= '0;
        drive_q <= 1'b0;
      end else if (stop_p) begin
        state   <= ST_IDLE;
        drive_q <= 1'b0;
      end else begin
        unique case (state)
          ST_DEVA: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (shreg[7:1] == DEV_ADDR) begin
                drive_q <= 1'b1;
                rw_q    <= shreg[0];
                state   <= ST_DACK;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_DACK: begin
            if (scl_fall) begin
              drive_q <= 1'b0;
              bitcnt  <= '0;
              if (rw_q) begin
                state <= ST_FETCH;
              end else begin
                state   <= ST_RXB;
                first_q <= 1'b1;
              end
            end
          end
          ST_RXB: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              drive_q <= 1'b1;
              state   <= ST_RACK;
              if (first_q) begin
                ptr     <= shreg[PTR_W-1:0];
                first_q <= 1'b0;
              end else begin
                wr_q    <= 1'b1;
                wdata_q <= shreg;
              end
            end
          end
          ST_RACK: begin
            if (scl_fall) begin
              drive_q <= 1'b0;
              bitcnt  <= '0;
              state   <= ST_RXB;
            end
          end
          ST_FETCH: state <= ST_LOAD;
          ST_LOAD: begin
            shreg   <= rdata;
            drive_q <= ~rdata[7];
            bitcnt  <= '0;
            ptr     <= ptr + 1'b1;
            state   <= ST_TXB;
          end
          ST_TXB: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                drive_q <= 1'b0;
                state   <= ST_TACK;
              end else begin
                drive_q <= ~shreg[6];
                shreg   <= {shreg[6:0], 1'b0};
                bitcnt  <= bitcnt + 1'b1;
              end
            end
          end
          ST_TACK: begin
            if (scl_rise) begin
              nack_q <= sda_s;
            end else if (scl_fall) begin
              state <= nack_q ? ST_SKIP : ST_FETCH;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign drive_low = drive_q;
  assign acc_wr    = wr_q;
  assign acc_rd    = (state == ST_FETCH);
  assign acc_ptr   = ptr;
  assign acc_wdata = wdata_q;
endmodule

// File: rtl/tw_space_map.sv
`timescale 1ns/1ps
module tw_space_map
  import tw_pkg::*;
#(
  parameter int         PTR_W     = 8,
  parameter int         REG_DEPTH = 48,
  parameter int         LOG_AW    = 11,
  parameter logic [7:0] WIN_BASE  = 8'h41
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_wr,
  input  logic              acc_rd,
  input  logic [PTR_W-1:0]  acc_ptr,
  input  logic [7:0]        acc_wdata,
  output logic [7:0]        acc_rdata,
  output logic              reg_we,
  output logic              reg_re,
  output logic [$clog2(REG_DEPTH)-1:0] reg_addr,
  output logic [7:0]        reg_wdata,
  input  logic [7:0]        reg_rdata,
  output logic              log_we,
  output logic              log_re,
  output logic [LOG_AW-1:0] log_addr,
  output logic [7:0]        log_wdata,
  input  logic [7:0]        log_rdata
);
  localparam int RAW  = $clog2(REG_DEPTH);
  localparam int HI_W = LOG_AW - 8;

  tw_region_e        region, sel_q;
  logic [LOG_AW-1:0] lp_q;
  logic [7:0]        idx_byte_q;
  logic [7:0]        lo_byte, hi_byte;

  always_comb begin
    if (int'(acc_ptr) < REG_DEPTH)          region = RG_REG;
    else if (acc_ptr == PTR_W'(WIN_BASE))    region = RG_LPLO;
    else if (acc_ptr == PTR_W'(WIN_BASE+1))  region = RG_LPHI;
    else if (acc_ptr == PTR_W'(WIN_BASE+2))  region = RG_LOG;
    else                                     region = RG_NONE;
  end

  assign lo_byte = lp_q[7:0];
  assign hi_byte = {{(8-HI_W){1'b0}}, lp_q[LOG_AW-1:8]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_q       <= '0;
      sel_q      <= RG_NONE;
      idx_byte_q <= '0;
    end else begin
      if (acc_rd) begin
        sel_q      <= region;
        idx_byte_q <= (region == RG_LPHI) ? hi_byte : lo_byte;
      end
      if (acc_wr && region == RG_LPLO) lp_q[7:0] <= acc_wdata;
      if (acc_wr && region == RG_LPHI) lp_q[LOG_AW-1:8] <= acc_wdata[HI_W-1:0];
      if ((acc_wr || acc_rd) && region == RG_LOG) lp_q <= lp_q + 1'b1;
    end
  end

  always_comb begin
    unique case (sel_q)
      RG_REG:           acc_rdata = reg_rdata;
      RG_LOG:           acc_rdata = log_rdata;
      RG_LPLO, RG_LPHI: acc_rdata = idx_byte_q;
      default:          acc_rdata = 8'h00;
    endcase
  end

  assign reg_we    = acc_wr && region == RG_REG;
  assign reg_re    = acc_rd && region == RG_REG;
  assign reg_addr  = acc_ptr[RAW-1:0];
  assign reg_wdata = acc_wdata;
  assign log_we    = acc_wr && region == RG_LOG;
  assign log_re    = acc_rd && region == RG_LOG;
  assign log_addr  = lp_q;
  assign log_wdata = acc_wdata;
endmodule

// File: rtl/twowire_reg_slave.sv
`timescale 1ns/1ps
module twowire_reg_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h52,
  parameter int         SYNC_STAGES = 2,
  parameter int         REG_DEPTH   = 48,
  parameter int         LOG_AW      = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_drive_low,
  output logic              reg_we,
  output logic              reg_re,
  output logic [5:0]        reg_addr,
  output logic [7:0]        reg_wdata,
  input  logic [7:0]        reg_rdata,
  output logic              log_we,
  output logic              log_re,
  output logic [10:0]       log_addr,
  output logic [7:0]        log_wdata,
  input  logic [7:0]        log_rdata
);
  localparam int PTR_W = 8;

  logic             scl_s, sda_s, start_p, stop_p;
  logic             acc_wr, acc_rd;
  logic [PTR_W-1:0] acc_ptr;
  logic [7:0]       acc_wdata, acc_rdata;

  tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .start_p(start_p), .stop_p(stop_p)
  );

  tw_byte_engine #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .start_p(start_p), .stop_p(stop_p), .rdata(acc_rdata),
    .drive_low(sda_drive_low), .acc_wr(acc_wr), .acc_rd(acc_rd),
    .acc_ptr(acc_ptr), .acc_wdata(acc_wdata)
  );

  tw_space_map #(.PTR_W(PTR_W), .REG_DEPTH(REG_DEPTH), .LOG_AW(LOG_AW)) u_map (
    .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_rd(acc_rd),
    .acc_ptr(acc_ptr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .log_we(log_we), .log_re(log_re), .log_addr(log_addr),
    .log_wdata(log_wdata), .log_rdata(log_rdata)
  );
endmodule

// File: rtl/tw_chk.sv
`timescale 1ns/1ps
module tw_chk #(
  parameter int REG_DEPTH = 48,
  parameter int LOG_AW    = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              stop_p,
  input logic              sda_drive_low,
  input logic              reg_we,
  input logic              reg_re,
  input logic [5:0]        reg_addr,
  input logic              log_we,
  input logic              log_re,
  input logic [LOG_AW-1:0] log_addr
);
  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_we, reg_re, log_we, log_re}));

  // R10
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we || log_we) |=> !(reg_we || log_we));

  // R5
  reg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we || reg_re) |-> (int'(reg_addr) < REG_DEPTH));

  // R8
  log_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (log_we || log_re) |=> (log_addr == $past(log_addr) + 1'b1));

  // R1
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |=> !sda_drive_low);

  // R4
  drive_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_low) |-> !$past(scl_s));
endmodule

bind twowire_reg_slave tw_chk #(.REG_DEPTH(REG_DEPTH), .LOG_AW(LOG_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_p(stop_p),
  .sda_drive_low(sda_drive_low), .reg_we(reg_we), .reg_re(reg_re),
  .reg_addr(reg_addr), .log_we(log_we), .log_re(log_re), .log_addr(log_addr)
);

// File: tb/sim_twowire_reg_slave.sv
`timescale 1ns/1ps
module sim_twowire_reg_slave;
  localparam int H = 20;
  localparam logic [6:0] DEV = 7'h52;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda_low = 1'b0;
  logic sda_drive_low, reg_we, reg_re, log_we, log_re;
  logic [5:0]  reg_addr;
  logic [10:0] log_addr;
  logic [7:0]  reg_wdata, log_wdata;
  logic [7:0]  reg_rdata = 8'h00;
  logic [7:0]  log_rdata = 8'h00;
  wire sda_line = ~(m_sda_low | sda_drive_low);

  logic [7:0] reg_mem [48];
  logic [7:0] log_mem [2048];

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_q[$];
  logic [7:0] act_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  twowire_reg_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_drive_low(sda_drive_low),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .log_we(log_we), .log_re(log_re), .log_addr(log_addr),
    .log_wdata(log_wdata), .log_rdata(log_rdata)
  );

  always @(posedge clk) begin
    if (reg_we) reg_mem[reg_addr] <= reg_wdata;
    if (reg_re) reg_rdata <= reg_mem[reg_addr];
    if (log_we) log_mem[log_addr] <= log_wdata;
    if (log_re) log_rdata <= log_mem[log_addr];
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic expect_byte(input string tag, input logic [7:0] v);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (act_q.size() > 0) begin
        logic [7:0] a;
        a = act_q.pop_front();
        if (exp_q.size() == 0) chk("unexpected read byte", a, 8'hxx);
        else chk(tag_q.pop_front(), a, exp_q.pop_front());
      end
    end
  end

  task automatic hw();
    repeat (H) @(negedge clk);
  endtask

  task automatic bstart();
    m_sda_low = 1'b0; hw();
    m_scl = 1'b1; hw();
    m_sda_low = 1'b1; hw();
    m_scl = 1'b0; hw();
  endtask

  task automatic bstop();
    m_sda_low = 1'b1; hw();
    m_scl = 1'b1; hw();
    m_sda_low = 1'b0; hw();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda_low = ~b[i]; hw();
      m_scl = 1'b1; hw();
      m_scl = 1'b0; hw();
    end
    m_sda_low = 1'b0; hw();
    m_scl = 1'b1;
    repeat (H/2) @(negedge clk);
    ack = (sda_line == 1'b0);
    repeat (H/2) @(negedge clk);
    m_scl = 1'b0; hw();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    m_sda_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      hw();
      m_scl = 1'b1;
      repeat (H/2) @(negedge clk);
      b[i] = sda_line;
      repeat (H/2) @(negedge clk);
      m_scl = 1'b0; hw();
    end
    m_sda_low = give_ack; hw();
    m_scl = 1'b1; hw();
    m_scl = 1'b0; hw();
    m_sda_low = 1'b0;
  endtask

  task automatic write_seq(input string tag, input logic [7:0] ptr, input int n,
                           input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
    logic ack;
    logic [7:0] d [3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    bstart();
    send_byte({DEV, 1'b0}, ack); chk({tag, " R2 address ack"}, {7'd0, ack}, 8'd1);
    send_byte(ptr, ack);         chk({tag, " R3 pointer ack"}, {7'd0, ack}, 8'd1);
    for (int k = 0; k < n; k++) begin
      send_byte(d[k], ack);      chk({tag, " R3 data ack"}, {7'd0, ack}, 8'd1);
    end
    bstop();
  endtask

  // pointer set, repeated START, n reads (last one NACKed)
  task automatic read_seq(input logic [7:0] ptr, input int n);
    logic ack;
    logic [7:0] b;
    bstart();
    send_byte({DEV, 1'b0}, ack); chk("R2 address ack (rd)", {7'd0, ack}, 8'd1);
    send_byte(ptr, ack);         chk("R3 pointer ack (rd)", {7'd0, ack}, 8'd1);
    bstart();
    send_byte({DEV, 1'b1}, ack); chk("R1 repeated START read ack", {7'd0, ack}, 8'd1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, b);
      act_q.push_back(b);
    end
    chk("R4 line released after NACK", {7'd0, sda_drive_low}, 8'd0);
    bstop();
  endtask

  initial begin
    for (int i = 0; i < 48; i++) reg_mem[i] = 8'hA0 + 8'(i);
    for (int i = 0; i < 2048; i++) log_mem[i] = 8'h00;
  end

  // watchdog
  initial begin
    repeat (150000) @(negedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic ack;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset drive", {7'd0, sda_drive_low}, 8'd0);
    chk("R10 reset strobes", {4'd0, reg_we, reg_re, log_we, log_re}, 8'd0);

    // R3 R5 sequential write and read-back
    write_seq("seq", 8'h00, 3, 8'h11, 8'h22, 8'h33);
    expect_byte("R4 R5 read 00h", 8'h11);
    expect_byte("R9 read 01h", 8'h22);
    expect_byte("R9 read 02h", 8'h33);
    read_seq(8'h00, 3);

    // R2 foreign address ignored
    bstart();
    send_byte({7'h23, 1'b0}, ack); chk("R2 foreign no ack", {7'd0, ack}, 8'd0);
    send_byte(8'h05, ack);         chk("R2 ignored pointer no ack", {7'd0, ack}, 8'd0);
    send_byte(8'h99, ack);
    bstop();
    expect_byte("R2 location 05h untouched", 8'hA5);
    read_seq(8'h05, 1);

    // R6 reserved locations
    write_seq("rsv", 8'h50, 1, 8'hEE, 8'h00, 8'h00);
    expect_byte("R6 50h write dropped, 10h intact", 8'hB0);
    read_seq(8'h10, 1);
    write_seq("rsv", 8'h35, 1, 8'h77, 8'h00, 8'h00);
    expect_byte("R6 35h reads 00", 8'h00);
    read_seq(8'h35, 1);
    expect_byte("R6 44h reads 00", 8'h00);
    expect_byte("R6 45h reads 00", 8'h00);
    read_seq(8'h44, 2);
    expect_byte("R6 40h reads 00", 8'h00);
    read_seq(8'h40, 1);

    // R7 log index masking
    write_seq("lidx", 8'h41, 2, 8'hFE, 8'hFF, 8'h00);
    expect_byte("R7 index low", 8'hFE);
    expect_byte("R7 index high masked", 8'h07);
    read_seq(8'h41, 2);

    // R8 log writes and wrap
    write_seq("lwr", 8'h43, 1, 8'h5A, 8'h00, 8'h00);
    write_seq("lwr", 8'h43, 1, 8'h6B, 8'h00, 8'h00);
    expect_byte("R8 index wrapped low", 8'h00);
    expect_byte("R8 index wrapped high", 8'h00);
    read_seq(8'h41, 2);
    write_seq("lidx", 8'h41, 2, 8'hFE, 8'h07, 8'h00);
    expect_byte("R8 log read 7FEh", 8'h5A);
    read_seq(8'h43, 1);
    expect_byte("R8 index after read low", 8'hFF);
    expect_byte("R8 index after read high", 8'h07);
    read_seq(8'h41, 2);
    expect_byte("R8 log read 7FFh", 8'h6B);
    read_seq(8'h43, 1);

    // R9 pointer wrap FFh -> 00h
    expect_byte("R9 read FFh", 8'h00);
    expect_byte("R9 wrapped to 00h", 8'h11);
    read_seq(8'hFF, 2);

    repeat (20) @(negedge clk);
    if (exp_q.size() != 0) chk("scoreboard drained", 8'(exp_q.size()), 8'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule